// File: doc/BRIEF.md
# Dual-Lane Banked Register File

This block is the general-purpose data register file of a two-lane SIMD datapath. Each lane, X and Y, holds two banks of sixteen 32-bit registers: a primary bank and a secondary bank. An interrupt handler can move between the two banks with one mode bit. No register contents are copied, so the context switch costs nothing beyond the change of that bit. A 32-bit register holds either a fixed-point word or a single-precision floating-point value. The file does not interpret the bits.

The compute units and the memory buses share six read ports and four write ports. A second mode bit turns on the Y lane. With that bit set, each access to register n moves two values: X-lane register n and Y-lane register n. The X lane always operates. When the Y lane is off, its read outputs are zero and writes aimed at it are dropped. When two write ports aim at the same register in one cycle, the higher-numbered port wins.

Top module: `dual_lane_regfile`

## Requirements
- R1: While `rst_n` is low, every register in both lanes and both banks is cleared to zero, the primary bank is made active and the Y lane is disabled. After reset, every read port returns zero until something is written.
- R2: A register address is 4 bits wide and selects register 0 to 15 within the active bank. The physical index is bank*16 + address, with bank 0 = primary and bank 1 = secondary. Six read ports return the addressed register combinationally, and four write ports update on the rising clock edge.
- R3: The mode inputs are registered. A change on `mode_alt_bank` (1 = secondary) or `mode_y_en` (1 = Y lane on) applies to accesses from the cycle after the change. Accesses in the cycle of the change still use the previous setting.
- R4: Switching banks preserves the contents of both banks. A value written before a switch reads back unchanged after switching away and back.
- R5: When two or more enabled write ports address the same register in one cycle, the data of the highest-numbered of those ports is stored, in both lanes.
- R6: A read of a register that is being written in the same cycle returns the value held before that write.
- R7: While the Y lane is disabled, every Y-lane read output is zero.
- R8: While the Y lane is disabled, writes leave every Y-lane register unchanged.
- R9: While the Y lane is enabled, a single access to register n reads, or writes, X-lane register n and Y-lane register n together.
- R10: The X lane reads and writes normally whatever the Y-lane setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_alt_bank | input | 1 | Bank select mode bit, 1 = secondary bank |
| mode_y_en | input | 1 | Y lane enable mode bit |
| rd_addr | input | 24 | Six 4-bit read addresses; port p is bits [4p+3:4p] |
| rd_x_data | output | 192 | Six X-lane read values; port p is bits [32p+31:32p] |
| rd_y_data | output | 192 | Six Y-lane read values; port p is bits [32p+31:32p] |
| wr_en | input | 4 | Write enable, one bit per write port |
| wr_addr | input | 16 | Four 4-bit write addresses; port p is bits [4p+3:4p] |
| wr_x_data | input | 128 | Four X-lane write values; port p is bits [32p+31:32p] |
| wr_y_data | input | 128 | Four Y-lane write values; port p is bits [32p+31:32p] |

## Verification
The hardest situation to reach from the ports is a Y-lane write that is dropped. Nothing shows it while the lane is off, because the Y outputs are then forced to zero. The stimulus therefore writes distinct Y data with the lane disabled, turns the lane on, waits out the one-cycle mode delay and reads the same addresses. Any leaked write would show as a non-zero value. Bank switches and write collisions are placed on registers that already hold known values, so that a wrong bank, a wrong winner or a write-through read shows up as a mismatch.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_NREGS  = 16;
  localparam int unsigned RF_NRD    = 6;
  localparam int unsigned RF_NWR    = 4;
  localparam int unsigned RF_NBANKS = 2;

  typedef enum logic {
    BANK_PRIMARY   = 1'b0,
    BANK_SECONDARY = 1'b1
  } bank_e;

  // Physical slot of a logical register within the two-bank array.
  function automatic int unsigned phys_slot(input logic bank, input int unsigned idx,
                                            input int unsigned nregs);
    return (bank ? nregs : 0) + idx;
  endfunction
endpackage

// File: rtl/rf_mode_reg.sv
module rf_mode_reg
  import rf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_alt_bank,
  input  logic  mode_y_en,
  output bank_e bank_q,
  output logic  yen_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_PRIMARY;
      yen_q  <= 1'b0;
    end else begin
      bank_q <= mode_alt_bank ? BANK_SECONDARY : BANK_PRIMARY;
      yen_q  <= mode_y_en;
    end
  end
endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int unsigned NWR   = 4,
  parameter int unsigned NREGS = 16,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned PW   = (NWR > 1) ? $clog2(NWR) : 1
) (
  input  logic [NWR-1:0]      wr_en,
  input  logic [NWR*AW-1:0]   wr_addr,
  output logic [NREGS-1:0]    reg_hit,
  output logic [NREGS*PW-1:0] reg_win
);
  // Highest-numbered enabled port whose address equals idx.
  function automatic logic [PW:0] pick_port(input logic [NWR-1:0] en,
                                            input logic [NWR*AW-1:0] addr,
                                            input int unsigned idx);
    logic [PW:0] res;
    res = '0;
    for (int p = 0; p < NWR; p++) begin
      if (en[p] && (addr[p*AW +: AW] == AW'(idx))) begin
        res = {1'b1, PW'(p)};
      end
    end
    return res;
  endfunction

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [PW:0] sel;
    always_comb sel = pick_port(wr_en, wr_addr, i);
    assign reg_hit[i]            = sel[PW];
    assign reg_win[i*PW +: PW]   = sel[PW-1:0];
  end
endmodule

// File: rtl/rf_lane_store.sv
module rf_lane_store
  import rf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 16,
  parameter int unsigned NWR   = 4,
  localparam int unsigned PW   = (NWR > 1) ? $clog2(NWR) : 1,
  localparam int unsigned NPHYS = 2 * NREGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lane_en,
  input  bank_e               bank,
  input  logic [NREGS-1:0]    reg_hit,
  input  logic [NREGS*PW-1:0] reg_win,
  input  logic [NWR*DW-1:0]   wr_data,
  output logic [NREGS-1:0]    lane_we,
  output logic [DW-1:0]       regs [NPHYS]
);
  assign lane_we = lane_en ? reg_hit : '0;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam int unsigned SLOT = phys_slot(b[0], i, NREGS);
      logic [PW-1:0] w;
      assign w = reg_win[i*PW +: PW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs[SLOT] <= '0;
        end else if (lane_we[i] && (bank == bank_e'(b[0]))) begin
          regs[SLOT] <= wr_data[w*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import rf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 16,
  parameter int unsigned NRD   = 6,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned NPHYS = 2 * NREGS
) (
  input  logic [DW-1:0]     regs [NPHYS],
  input  bank_e             bank,
  input  logic              lane_en,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);
  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [AW:0] slot;
    assign slot = {bank, rd_addr[p*AW +: AW]};
    assign rd_data[p*DW +: DW] = lane_en ? regs[slot] : '0;
  end
endmodule

// File: rtl/dual_lane_regfile.sv
module dual_lane_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DW    = RF_DATA_W,
  parameter int unsigned NREGS = RF_NREGS,
  parameter int unsigned NRD   = RF_NRD,
  parameter int unsigned NWR   = RF_NWR,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned PW   = (NWR > 1) ? $clog2(NWR) : 1,
  localparam int unsigned NPHYS = 2 * NREGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_alt_bank,
  input  logic              mode_y_en,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_x_data,
  output logic [NRD*DW-1:0] rd_y_data,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*DW-1:0] wr_x_data,
  input  logic [NWR*DW-1:0] wr_y_data
);
  bank_e               bank_q;
  logic                yen_q;
  logic [NREGS-1:0]    reg_hit;
  logic [NREGS*PW-1:0] reg_win;
  logic [NREGS-1:0]    x_we;
  logic [NREGS-1:0]    y_we;
  logic [DW-1:0]       x_regs [NPHYS];
  logic [DW-1:0]       y_regs [NPHYS];

  rf_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n),
    .mode_alt_bank(mode_alt_bank), .mode_y_en(mode_y_en),
    .bank_q(bank_q), .yen_q(yen_q)
  );

  rf_write_arb #(.NWR(NWR), .NREGS(NREGS)) u_arb (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .reg_hit(reg_hit), .reg_win(reg_win)
  );

  rf_lane_store #(.DW(DW), .NREGS(NREGS), .NWR(NWR)) u_x_store (
    .clk(clk), .rst_n(rst_n), .lane_en(1'b1), .bank(bank_q),
    .reg_hit(reg_hit), .reg_win(reg_win), .wr_data(wr_x_data),
    .lane_we(x_we), .regs(x_regs)
  );

  rf_lane_store #(.DW(DW), .NREGS(NREGS), .NWR(NWR)) u_y_store (
    .clk(clk), .rst_n(rst_n), .lane_en(yen_q), .bank(bank_q),
    .reg_hit(reg_hit), .reg_win(reg_win), .wr_data(wr_y_data),
    .lane_we(y_we), .regs(y_regs)
  );

  rf_read_mux #(.DW(DW), .NREGS(NREGS), .NRD(NRD)) u_x_rd (
    .regs(x_regs), .bank(bank_q), .lane_en(1'b1),
    .rd_addr(rd_addr), .rd_data(rd_x_data)
  );

  rf_read_mux #(.DW(DW), .NREGS(NREGS), .NRD(NRD)) u_y_rd (
    .regs(y_regs), .bank(bank_q), .lane_en(yen_q),
    .rd_addr(rd_addr), .rd_data(rd_y_data)
  );
endmodule

// File: rtl/dual_lane_regfile_chk.sv
module dual_lane_regfile_chk
  import rf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 16,
  parameter int unsigned NRD   = 6,
  parameter int unsigned NWR   = 4,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned PW   = (NWR > 1) ? $clog2(NWR) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_alt_bank,
  input logic                mode_y_en,
  input bank_e               bank_q,
  input logic                yen_q,
  input logic [NRD*DW-1:0]   rd_y_data,
  input logic [NWR-1:0]      wr_en,
  input logic [NWR*AW-1:0]   wr_addr,
  input logic [NREGS-1:0]    reg_hit,
  input logic [NREGS*PW-1:0] reg_win,
  input logic [NREGS-1:0]    y_we,
  input logic [NREGS-1:0]    x_we
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_reset_primary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (bank_q == BANK_PRIMARY) && !yen_q);

  assert_bank_follows_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (bank_q == (($past(mode_alt_bank)) ? BANK_SECONDARY : BANK_PRIMARY))
                && (yen_q == $past(mode_y_en)));

  assert_y_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !yen_q |-> (rd_y_data == '0));

  assert_y_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !yen_q |-> (y_we == '0));

  assert_x_always_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    x_we == reg_hit);

  assert_pair_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    yen_q |-> (y_we == x_we));

  for (genvar i = 0; i < NREGS; i++) begin : g_win
    logic [PW-1:0] w;
    logic          higher;
    assign w = reg_win[i*PW +: PW];
    always_comb begin
      higher = 1'b0;
      for (int p = 0; p < NWR; p++) begin
        if (p > int'(w) && wr_en[p] && wr_addr[p*AW +: AW] == AW'(i)) higher = 1'b1;
      end
    end
    assert_winner_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_hit[i] |-> wr_en[w] && (wr_addr[w*AW +: AW] == AW'(i)) && !higher);
  end
endmodule

bind dual_lane_regfile dual_lane_regfile_chk #(
  .DW(DW), .NREGS(NREGS), .NRD(NRD), .NWR(NWR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_alt_bank(mode_alt_bank), .mode_y_en(mode_y_en),
  .bank_q(bank_q), .yen_q(yen_q), .rd_y_data(rd_y_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .reg_hit(reg_hit), .reg_win(reg_win),
  .y_we(y_we), .x_we(x_we)
);

// File: tb/dual_lane_regfile_tb.sv
`timescale 1ns/1ps
module dual_lane_regfile_tb;
  localparam int DW = 32, NR = 16, NRD = 6, NWR = 4, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_alt_bank = 1'b0, mode_y_en = 1'b0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_x_data, rd_y_data;
  logic [NWR-1:0]    wr_en = '0;
  logic [NWR*AW-1:0] wr_addr = '0;
  logic [NWR*DW-1:0] wr_x_data = '0, wr_y_data = '0;

  always #10 clk = ~clk;

  dual_lane_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_alt_bank(mode_alt_bank), .mode_y_en(mode_y_en),
    .rd_addr(rd_addr), .rd_x_data(rd_x_data), .rd_y_data(rd_y_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_x_data(wr_x_data), .wr_y_data(wr_y_data)
  );

  // Stimulus variables set by the test sequence.
  logic [3:0]  ra [NRD];
  logic        we [NWR];
  logic [3:0]  wa [NWR];
  logic [31:0] wx [NWR];
  logic [31:0] wy [NWR];
  logic        s_alt, s_yen;

  // Bench model of the register file.
  logic [31:0] mx [32];
  logic [31:0] my [32];
  logic        m_bank, m_yen;

  // Scoreboard queues.
  int          q_port [$];
  logic        q_lane [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic clear_stim();
    for (int p = 0; p < NRD; p++) ra[p] = 4'(p);
    for (int p = 0; p < NWR; p++) begin
      we[p] = 1'b0; wa[p] = '0; wx[p] = '0; wy[p] = '0;
    end
  endtask

  // Driver: applies one cycle of stimulus, queues expected reads, advances the model.
  task automatic cycle(input string tag);
    @(posedge clk);
    #2;
    mode_alt_bank = s_alt;
    mode_y_en     = s_yen;
    for (int p = 0; p < NRD; p++) rd_addr[p*AW +: AW] = ra[p];
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = we[p];
      wr_addr[p*AW +: AW] = wa[p];
      wr_x_data[p*DW +: DW] = wx[p];
      wr_y_data[p*DW +: DW] = wy[p];
    end
    for (int p = 0; p < NRD; p++) begin
      q_port.push_back(p); q_lane.push_back(1'b0);
      q_exp.push_back(mx[{m_bank, ra[p]}]); q_tag.push_back(tag);
      q_port.push_back(p); q_lane.push_back(1'b1);
      q_exp.push_back(m_yen ? my[{m_bank, ra[p]}] : 32'h0); q_tag.push_back(tag);
    end
    if (rst_n) begin
      for (int p = 0; p < NWR; p++) begin
        if (we[p]) begin
          mx[{m_bank, wa[p]}] = wx[p];
          if (m_yen) my[{m_bank, wa[p]}] = wy[p];
        end
      end
      m_bank = s_alt;
      m_yen  = s_yen;
    end
  endtask

  // Monitor: compares queued expectations mid-cycle.
  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      int p; logic l; logic [31:0] e, a; string t;
      p = q_port.pop_front(); l = q_lane.pop_front();
      e = q_exp.pop_front();  t = q_tag.pop_front();
      a = l ? rd_y_data[p*DW +: DW] : rd_x_data[p*DW +: DW];
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s lane=%s port=%0d actual=%08h expected=%08h",
                 t, l ? "Y" : "X", p, a, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mx[i] = '0; my[i] = '0; end
    m_bank = 1'b0; m_yen = 1'b0; s_alt = 1'b0; s_yen = 1'b0;
    clear_stim();

    // R1: reset state, reads of several addresses return zero.
    cycle("R1 reset");
    for (int p = 0; p < NRD; p++) ra[p] = 4'(15 - p);
    cycle("R1 reset");
    @(posedge clk); #2 rst_n = 1'b1;

    // R10 R8: X writes with Y lane off, Y data offered but dropped.
    for (int p = 0; p < NWR; p++) begin
      we[p] = 1'b1; wa[p] = 4'(p); wx[p] = 32'h1000_0000 + p; wy[p] = 32'hdead_0000 + p;
    end
    cycle("R10 write X lane off");
    clear_stim();
    cycle("R10 R7 read back X, Y zero");

    // R3: enable Y lane; this cycle still reads Y as zero.
    s_yen = 1'b1;
    cycle("R3 Y enable delayed");
    cycle("R8 dropped Y writes read zero");

    // R9 R6: SIMD pair writes, read of same registers in same cycle is old.
    we[0] = 1'b1; wa[0] = 4'd5; wx[0] = 32'haaaa_0005; wy[0] = 32'hbbbb_0005;
    we[2] = 1'b1; wa[2] = 4'd6; wx[2] = 32'haaaa_0006; wy[2] = 32'hbbbb_0006;
    ra[0] = 4'd5; ra[1] = 4'd6;
    cycle("R6 read during write old value");
    clear_stim(); ra[0] = 4'd5; ra[1] = 4'd6;
    cycle("R9 pair read");

    // R5: collision on register 7 from ports 0,1,3; on 8 from ports 0 and 2.
    we[0] = 1'b1; wa[0] = 4'd7; wx[0] = 32'h0000_0070; wy[0] = 32'h0000_0170;
    we[1] = 1'b1; wa[1] = 4'd7; wx[1] = 32'h0000_0071; wy[1] = 32'h0000_0171;
    we[3] = 1'b1; wa[3] = 4'd7; wx[3] = 32'h0000_0073; wy[3] = 32'h0000_0173;
    cycle("R5 collision three ports");
    clear_stim();
    we[0] = 1'b1; wa[0] = 4'd8; wx[0] = 32'h0000_0080; wy[0] = 32'h0000_0180;
    we[2] = 1'b1; wa[2] = 4'd8; wx[2] = 32'h0000_0082; wy[2] = 32'h0000_0182;
    we[3] = 1'b1; wa[3] = 4'd9; wx[3] = 32'h0000_0093; wy[3] = 32'h0000_0193;
    cycle("R5 collision two ports");
    clear_stim(); ra[0] = 4'd7; ra[1] = 4'd8; ra[2] = 4'd9;
    cycle("R5 winners");

    // R3 R2: bank switch applies next cycle.
    s_alt = 1'b1;
    cycle("R3 bank switch delayed");
    cycle("R2 secondary bank empty");
    we[1] = 1'b1; wa[1] = 4'd0; wx[1] = 32'h5ec0_0000; wy[1] = 32'h5ec1_0000;
    we[3] = 1'b1; wa[3] = 4'd7; wx[3] = 32'h5ec0_0007; wy[3] = 32'h5ec1_0007;
    cycle("R2 write secondary");
    clear_stim(); ra[4] = 4'd7;
    s_alt = 1'b0;
    cycle("R2 read secondary");
    cycle("R4 primary preserved");
    s_alt = 1'b1;
    cycle("R4 primary preserved before switch");
    cycle("R4 secondary preserved");

    // R7 R10: Y lane off again, X keeps working.
    s_yen = 1'b0;
    we[2] = 1'b1; wa[2] = 4'd3; wx[2] = 32'h7777_0003; wy[2] = 32'h8888_0003;
    cycle("R10 write while disabling");
    clear_stim(); ra[3] = 4'd3;
    cycle("R7 Y zero after disable");
    s_yen = 1'b1;
    cycle("R3 re-enable delayed");
    cycle("R8 Y kept across disable");
    @(posedge clk);
    @(negedge clk);
    #1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule